// File: doc/BRIEF.md
# Accumulator ALU with Link and Decimal Add

This block is the arithmetic and logic stage of a small accumulator machine. Each accepted request presents the accumulator value, a second operand (a memory byte or an extension register, chosen upstream) and the current carry/link flag, together with an operation code. One clock later the block presents the 8-bit result, the new link and overflow values, and a write enable for each flag. The surrounding core commits a flag only when its enable is high.

The operation set covers load, AND, OR and XOR, binary add with link, and complement-and-add, which is the only way to subtract: the link acts as an inverted borrow. It also covers two-digit BCD addition, which leaves overflow alone, and four right shift and rotate forms. Two of those forms feed the link into bit 7. Operand fetch, decode and delay loops belong elsewhere.

Top module: `acc_alu`

## Requirements
- R1: Outputs are registered. A request sampled with `in_valid`=1 appears on the outputs one clock later with `out_valid`=1. A cycle without `in_valid` drives `out_valid` to 0 and holds `res_out`, `link_out`, `ovf_out`, `link_we` and `ovf_we`. Synchronous reset clears every output to 0.
- R2: Op code 0 (load) gives `res_out` = operand, with `link_we`=0 and `ovf_we`=0.
- R3: Op codes 1, 2 and 3 give accumulator AND, OR and XOR operand, with both flag enables at 0.
- R4: Op code 4 (add) gives accumulator + operand + link. `link_out` is the carry out of bit 7, and `link_we`=1 and `ovf_we`=1.
- R5: Op code 5 (complement-and-add) gives accumulator + (bitwise NOT operand) + link, with carry and enables as in R4.
- R6: For op codes 4 and 5, `ovf_out`=1 exactly when the signed sum of the accumulator and the added operand (after inversion for op 5) plus the link falls outside -128..127.
- R7: Op code 6 (decimal add) treats both inputs as two BCD digits. The result is the BCD value of (acc + operand + link) mod 100, and `link_out`=1 when that sum is 100 or more. `link_we`=1 and `ovf_we`=0.
- R8: Op code 7 shifts the accumulator right by one with 0 into bit 7. Op code 8 shifts right with the incoming link into bit 7. Neither op writes a flag.
- R9: Op code 9 rotates the accumulator right, bit 0 into bit 7, and writes no flag.
- R10: Op code 10 rotates the nine bits {link, acc} right. The old link goes into bit 7, `link_out` = old acc bit 0, `link_we`=1 and `ovf_we`=0.
- R11: Op codes 11 to 15 return the accumulator unchanged, with both flag enables at 0.
- R12: Whenever `link_we`=0, `link_out` equals the sampled `link_in`. Whenever `ovf_we`=0, `ovf_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op_in | input | 4 | Operation code |
| acc_in | input | 8 | Accumulator value |
| opnd_in | input | 8 | Second operand |
| link_in | input | 1 | Current carry/link flag |
| out_valid | output | 1 | Result valid |
| res_out | output | 8 | Result byte |
| link_out | output | 1 | New link value |
| ovf_out | output | 1 | New overflow value |
| link_we | output | 1 | Commit link |
| ovf_we | output | 1 | Commit overflow |

## Verification
The bench targets signed overflow at the 0x7F/0x80 boundary, both for add and for subtraction through the complement. A design that tested the raw operand rather than the inverted one would flag the wrong cases. Decimal add is driven with digit carries into each nibble and out of the top, such as 99+01 and 99+99+1. A missing correction or a wrong carry chain shows up as non-BCD digits or a lost carry, and any overflow enable on that op is reported. The shift forms are run with the link set, so a design that swapped the zero fill, the link fill and the nine-bit rotate is caught by bit 7 and by the link output. Unused op codes, held outputs between requests, and the link pass-through on flagless ops are checked as well.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD = 4'd0,
    OP_AND  = 4'd1,
    OP_OR   = 4'd2,
    OP_XOR  = 4'd3,
    OP_ADD  = 4'd4,
    OP_CADD = 4'd5,
    OP_DADD = 4'd6,
    OP_SR   = 4'd7,
    OP_SRL  = 4'd8,
    OP_RR   = 4'd9,
    OP_RRL  = 4'd10
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_ZERO = 2'd0,
    SH_LINK = 2'd1,
    SH_ROT  = 2'd2,
    SH_ROTL = 2'd3
  } shift_mode_e;

  typedef enum logic [1:0] {
    LG_PASS = 2'd0,
    LG_AND  = 2'd1,
    LG_OR   = 2'd2,
    LG_XOR  = 2'd3
  } logic_sel_e;
endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic_sel_e     sel,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   y
);
  always_comb begin
    unique case (sel)
      LG_PASS: y = b;
      LG_AND:  y = a & b;
      LG_OR:   y = a | b;
      LG_XOR:  y = a ^ b;
      default: y = b;
    endcase
  end
endmodule

// File: rtl/alu_bin_adder.sv
module alu_bin_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         invert_b,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  localparam int MSB = W - 1;

  logic [W-1:0] b_eff;
  logic [W:0]   wide;

  always_comb begin
    b_eff = invert_b ? ~b : b;
    wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
    sum   = wide[W-1:0];
    cout  = wide[W];
    ovf   = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
  end
endmodule

// File: rtl/alu_bcd_adder.sv
module alu_bcd_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  localparam int DIGITS = W / 4;

  logic [DIGITS:0] dcar;

  assign dcar[0] = cin;
  assign cout    = dcar[DIGITS];

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [4:0] raw;
    logic [4:0] fixed;
    always_comb begin
      raw = {1'b0, a[g*4 +: 4]} + {1'b0, b[g*4 +: 4]} + {4'd0, dcar[g]};
      if (raw > 5'd9) begin
        fixed       = raw + 5'd6;
        dcar[g + 1] = 1'b1;
      end else begin
        fixed       = raw;
        dcar[g + 1] = 1'b0;
      end
      sum[g*4 +: 4] = fixed[3:0];
    end
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  shift_mode_e  mode,
  input  logic [W-1:0] a,
  input  logic         lin,
  output logic [W-1:0] y,
  output logic         lout
);
  logic fill;

  always_comb begin
    unique case (mode)
      SH_ZERO: fill = 1'b0;
      SH_LINK: fill = lin;
      SH_ROT:  fill = a[0];
      SH_ROTL: fill = lin;
      default: fill = 1'b0;
    endcase
    y    = {fill, a[W-1:1]};
    lout = (mode == SH_ROTL) ? a[0] : lin;
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [3:0]   op_in,
  input  logic [7:0]   acc_in,
  input  logic [7:0]   opnd_in,
  input  logic         link_in,
  output logic         out_valid,
  output logic [7:0]   res_out,
  output logic         link_out,
  output logic         ovf_out,
  output logic         link_we,
  output logic         ovf_we
);
  localparam int MSB = W - 1;

  logic_sel_e  lg_sel;
  shift_mode_e sh_mode;
  logic [W-1:0] lg_y, add_y, bcd_y, sh_y;
  logic add_c, add_v, bcd_c, sh_l;

  logic [W-1:0] res_n;
  logic link_n, ovf_n, lwe_n, owe_n;
  logic [3:0] op_q;

  always_comb begin
    unique case (op_in)
      OP_AND:  lg_sel = LG_AND;
      OP_OR:   lg_sel = LG_OR;
      OP_XOR:  lg_sel = LG_XOR;
      default: lg_sel = LG_PASS;
    endcase
    unique case (op_in)
      OP_SRL:  sh_mode = SH_LINK;
      OP_RR:   sh_mode = SH_ROT;
      OP_RRL:  sh_mode = SH_ROTL;
      default: sh_mode = SH_ZERO;
    endcase
  end

  alu_logic_unit #(.W(W)) u_logic (
    .sel(lg_sel), .a(acc_in), .b(opnd_in), .y(lg_y)
  );

  alu_bin_adder #(.W(W)) u_add (
    .a(acc_in), .b(opnd_in), .cin(link_in),
    .invert_b(op_in == OP_CADD),
    .sum(add_y), .cout(add_c), .ovf(add_v)
  );

  alu_bcd_adder #(.W(W)) u_bcd (
    .a(acc_in), .b(opnd_in), .cin(link_in), .sum(bcd_y), .cout(bcd_c)
  );

  alu_shifter #(.W(W)) u_shift (
    .mode(sh_mode), .a(acc_in), .lin(link_in), .y(sh_y), .lout(sh_l)
  );

  always_comb begin
    res_n  = acc_in;
    link_n = link_in;
    ovf_n  = 1'b0;
    lwe_n  = 1'b0;
    owe_n  = 1'b0;
    unique case (op_in)
      OP_LOAD, OP_AND, OP_OR, OP_XOR: res_n = lg_y;
      OP_ADD, OP_CADD: begin
        res_n  = add_y;
        link_n = add_c;
        ovf_n  = add_v;
        lwe_n  = 1'b1;
        owe_n  = 1'b1;
      end
      OP_DADD: begin
        res_n  = bcd_y;
        link_n = bcd_c;
        lwe_n  = 1'b1;
      end
      OP_SR, OP_SRL, OP_RR: res_n = sh_y;
      OP_RRL: begin
        res_n  = sh_y;
        link_n = sh_l;
        lwe_n  = 1'b1;
      end
      default: res_n = acc_in;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      res_out   <= '0;
      link_out  <= 1'b0;
      ovf_out   <= 1'b0;
      link_we   <= 1'b0;
      ovf_we    <= 1'b0;
      op_q      <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        res_out  <= res_n;
        link_out <= link_n;
        ovf_out  <= ovf_n;
        link_we  <= lwe_n;
        ovf_we   <= owe_n;
        op_q     <= op_in;
      end
    end
  end

  assert_valid_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(res_out) && $stable(link_we)));

  assert_logic_noflag_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && op_q >= 4'd1 && op_q <= 4'd3) |-> (!link_we && !ovf_we));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && op_q == OP_DADD) |-> (link_we && !ovf_we));

  assert_sr_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && op_q == OP_SR) |-> !res_out[MSB]);

  assert_rrl_link_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_in == OP_RRL) |=>
      (link_we && link_out == $past(acc_in[0]) && res_out[MSB] == $past(link_in)));

  assert_ovf_gate_R12: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !ovf_we) |-> !ovf_out);
endmodule

// File: tb/tb_acc_alu.sv
module tb_acc_alu;
  logic clk = 1'b0;
  logic rst;
  logic in_valid;
  logic [3:0] op_in;
  logic [7:0] acc_in, opnd_in;
  logic link_in;
  logic out_valid, link_out, ovf_out, link_we, ovf_we;
  logic [7:0] res_out;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  acc_alu dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_in(op_in),
    .acc_in(acc_in), .opnd_in(opnd_in), .link_in(link_in),
    .out_valid(out_valid), .res_out(res_out), .link_out(link_out),
    .ovf_out(ovf_out), .link_we(link_we), .ovf_we(ovf_we)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic issue(input int op, input int a, input int b, input bit l);
    @(negedge clk);
    op_in = op[3:0]; acc_in = a[7:0]; opnd_in = b[7:0]; link_in = l;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_all(input string req, input int r, input bit l,
                            input bit v, input bit lwe, input bit owe);
    chk({req, " valid"}, out_valid, 1);
    chk({req, " res"}, res_out, r);
    chk({req, " link"}, link_out, l);
    chk({req, " ovf"}, ovf_out, v);
    chk({req, " link_we"}, link_we, lwe);
    chk({req, " ovf_we"}, ovf_we, owe);
  endtask

  function automatic int sx(input int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  task automatic run_bin(input bit cmp, input int a, input int b, input bit l);
    int bb = cmp ? (~b & 255) : b;
    int s = a + bb + l;
    int ss = sx(a) + sx(bb) + l;
    bit v = (ss > 127) || (ss < -128);
    issue(cmp ? 5 : 4, a, b, l);
    expect_all(cmp ? "R5/R6 cadd" : "R4/R6 add", s & 255, s > 255, v, 1, 1);
  endtask

  task automatic run_bcd(input int a, input int b, input bit l);
    int da = (a >> 4) * 10 + (a & 15);
    int db = (b >> 4) * 10 + (b & 15);
    int s = da + db + l;
    int m = s % 100;
    issue(6, a, b, l);
    expect_all("R7 dadd", ((m / 10) << 4) | (m % 10), s >= 100, 0, 1, 0);
  endtask

  task automatic t_reset;
    chk("R1 reset valid", out_valid, 0);
    chk("R1 reset res", res_out, 0);
    chk("R1 reset we", {link_we, ovf_we, link_out, ovf_out}, 0);
  endtask

  task automatic t_load_logic;
    issue(0, 8'h12, 8'hA5, 1'b1); expect_all("R2 load", 8'hA5, 1, 0, 0, 0);
    issue(1, 8'hF0, 8'h3C, 1'b0); expect_all("R3 and", 8'h30, 0, 0, 0, 0);
    issue(2, 8'hF0, 8'h3C, 1'b1); expect_all("R3 or R12", 8'hFC, 1, 0, 0, 0);
    issue(3, 8'hF0, 8'h3C, 1'b0); expect_all("R3 xor", 8'hCC, 0, 0, 0, 0);
  endtask

  task automatic t_arith;
    run_bin(0, 8'h7F, 8'h01, 0);
    run_bin(0, 8'hFF, 8'h01, 0);
    run_bin(0, 8'h80, 8'h80, 1);
    run_bin(0, 8'h12, 8'h34, 1);
    run_bin(1, 8'h05, 8'h03, 1);
    run_bin(1, 8'h03, 8'h05, 1);
    run_bin(1, 8'h80, 8'h01, 1);
    run_bin(1, 8'h7F, 8'hFF, 0);
  endtask

  task automatic t_decimal;
    run_bcd(8'h45, 8'h38, 0);
    run_bcd(8'h99, 8'h01, 0);
    run_bcd(8'h99, 8'h99, 1);
    run_bcd(8'h09, 8'h00, 1);
    run_bcd(8'h50, 8'h49, 0);
  endtask

  task automatic t_shift;
    issue(7, 8'hB5, 0, 1'b1); expect_all("R8 sr", 8'h5A, 1, 0, 0, 0);
    issue(8, 8'hB4, 0, 1'b1); expect_all("R8 srl", 8'hDA, 1, 0, 0, 0);
    issue(8, 8'hB5, 0, 1'b0); expect_all("R8 srl0", 8'h5A, 0, 0, 0, 0);
    issue(9, 8'h01, 0, 1'b0); expect_all("R9 rr", 8'h80, 0, 0, 0, 0);
    issue(10, 8'h01, 0, 1'b0); expect_all("R10 rrl", 8'h00, 1, 0, 1, 0);
    issue(10, 8'h02, 0, 1'b1); expect_all("R10 rrl link", 8'h81, 0, 0, 1, 0);
  endtask

  task automatic t_unused;
    for (int k = 11; k < 16; k++) begin
      issue(k, 8'h6B, 8'hFF, 1'b1);
      expect_all("R11 unused op", 8'h6B, 1, 0, 0, 0);
    end
  endtask

  task automatic t_hold;
    issue(4, 8'h7F, 8'h01, 0);
    @(negedge clk);
    opnd_in = 8'h55; acc_in = 8'h00;
    @(negedge clk);
    chk("R1 idle valid", out_valid, 0);
    chk("R1 hold res", res_out, 8'h80);
    chk("R1 hold flags", {link_out, ovf_out, link_we, ovf_we}, 4'b0111);
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; op_in = 0; acc_in = 0; opnd_in = 0; link_in = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_load_logic;
    t_arith;
    t_decimal;
    t_shift;
    t_unused;
    t_hold;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule